// File: doc/BRIEF.md
# Microwire EEPROM read sequencer

This block fetches one 16-bit word from a three-wire serial EEPROM of the Microwire kind. The host places a word address on `addr_i`, selects the address width with `wide_i` and pulses `start_i`. The sequencer raises chip select and clocks out a serial command made of the read opcode and the address. It then clocks in sixteen data bits, releases chip select, waits one idle bit period and returns the word on `word_o` together with a one-cycle `done_o` pulse.

All serial timing comes from one divider. The `HALF_DIV` parameter gives the number of system clocks in each half of a serial bit, so the same block can run from any system clock. For example, 1250 clocks at 125 MHz gives the usual 10 µs half period. The address width can change from one read to the next: 6-bit parts take a 9-bit command and 8-bit parts take an 11-bit command. `busy_o` covers the whole transfer. A start request that arrives during a transfer is dropped.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset `cs_o`, `sk_o`, `di_o`, `busy_o` and `done_o` are low and `word_o` is zero.
- R2: `addr_i` and `wide_i` are captured in the cycle a start is accepted. The first N rising edges of `sk_o` in a select window carry on `di_o`, MSB first, the bits 1, 1, 0 followed by the address. With `wide_i`=1, N is 11 and the address is `addr_i[7:0]`. With `wide_i`=0, N is 9 and the address is `addr_i[5:0]`.
- R3: With `wide_i`=0, bits 7:6 of `addr_i` have no effect on the command sent or on the word returned.
- R4: The next 16 rising edges of `sk_o` each take one data bit, MSB first. Each bit is the level of `do_i` at the end of that high half, and the assembled word is what appears on `word_o`.
- R5: While chip select is high, every high half of `sk_o` lasts exactly `HALF_DIV` clocks, and `di_o` does not change while `sk_o` stays high.
- R6: `cs_o` rises in the cycle after a start is accepted. It stays high with `sk_o` low for 2·`HALF_DIV` clocks before the first rising edge of `sk_o`, and it falls with the last falling edge of `sk_o`. Each select window holds exactly N+16 rising edges, and `sk_o` is low whenever `cs_o` is low.
- R7: `done_o` is a one-cycle pulse that comes `HALF_DIV`·(35+2N) clocks after the edge that accepts the start. `word_o` takes its new value in the same cycle and holds it until the next `done_o`.
- R8: `busy_o` rises only on an accepted start and stays high until the `done_o` cycle, where it falls. A `start_i` pulse seen while busy changes neither the address being read nor the returned word.
- R9: After `cs_o` falls, it stays low for at least 2·`HALF_DIV` clocks before it rises again. A start asserted in the `done_o` cycle is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Read request, sampled while idle |
| addr_i | input | ADDR_LONG | Word address (low ADDR_SHORT bits used in short mode) |
| wide_i | input | 1 | 1: long address field, 0: short address field |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when `word_o` is updated |
| word_o | output | DATA_W | Last word read |
| cs_o | output | 1 | EEPROM chip select |
| sk_o | output | 1 | EEPROM serial clock |
| di_o | output | 1 | Serial data towards the EEPROM |
| do_i | input | 1 | Serial data from the EEPROM |

## Verification
The completion of one read and the acceptance of the next can fall in the same cycle. `done_o` and the drop of `busy_o` arrive together, so a start held high in that cycle is taken on the following edge. The bench provokes this by raising `start_i` at the very sample where it first sees `done_o`, then issuing the next read without waiting. It judges the result in two ways: the second word and its decoded command must be correct, and the shortest low time measured on `cs_o` across the whole run must still be at least one full bit period.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    MW_IDLE,
    MW_LEAD,
    MW_CMD_LO,
    MW_CMD_HI,
    MW_DAT_LO,
    MW_DAT_HI,
    MW_GAP
  } mw_phase_t;

  localparam logic [2:0] MW_READ_OP = 3'b110;
endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
  parameter int HALF_DIV = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mw_cmd_shifter.sv
module mw_cmd_shifter
  import mw_pkg::*;
#(
  parameter int ADDR_LONG  = 8,
  parameter int ADDR_SHORT = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 wide,
  input  logic [ADDR_LONG-1:0] addr,
  input  logic                 shift,
  output logic                 bit_o,
  output logic                 last_o
);
  localparam int FW   = 3 + ADDR_LONG;
  localparam int SW   = 3 + ADDR_SHORT;
  localparam int PAD  = ADDR_LONG - ADDR_SHORT;
  localparam int CNTW = $clog2(FW + 1);

  logic [FW-1:0]   frame;
  logic [CNTW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame  <= '0;
      remain <= '0;
    end else if (load) begin
      if (wide) begin
        frame  <= {MW_READ_OP, addr};
        remain <= CNTW'(FW);
      end else begin
        frame  <= {MW_READ_OP, addr[ADDR_SHORT-1:0], {PAD{1'b0}}};
        remain <= CNTW'(SW);
      end
    end else if (shift) begin
      frame  <= {frame[FW-2:0], 1'b0};
      remain <= remain - 1'b1;
    end
  end

  assign bit_o  = frame[FW-1];
  assign last_o = (remain == CNTW'(1));
endmodule

// File: rtl/mw_data_shifter.sv
module mw_data_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst || clear)  word <= '0;
    else if (sample)   word <= {word[DATA_W-2:0], din};
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int HALF_DIV   = 1250,
  parameter int DATA_W     = 16,
  parameter int ADDR_LONG  = 8,
  parameter int ADDR_SHORT = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [ADDR_LONG-1:0] addr_i,
  input  logic                 wide_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [DATA_W-1:0]    word_o,
  output logic                 cs_o,
  output logic                 sk_o,
  output logic                 di_o,
  input  logic                 do_i
);
  localparam int DCW = $clog2(DATA_W);
  localparam logic [DCW-1:0] DLAST = DCW'(DATA_W - 1);

  mw_phase_t       phase;
  logic [DCW-1:0]  dcnt;
  logic            gap_half;
  logic            tick;
  logic            accept;
  logic            cmd_shift;
  logic            cmd_last;
  logic            dat_sample;
  logic [DATA_W-1:0] rx_word;

  assign accept     = (phase == MW_IDLE) && start_i;
  assign cmd_shift  = (phase == MW_CMD_HI) && tick;
  assign dat_sample = (phase == MW_DAT_HI) && tick;

  mw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .run   (busy_o),
    .tick  (tick)
  );

  mw_cmd_shifter #(.ADDR_LONG(ADDR_LONG), .ADDR_SHORT(ADDR_SHORT)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .wide   (wide_i),
    .addr   (addr_i),
    .shift  (cmd_shift),
    .bit_o  (di_o),
    .last_o (cmd_last)
  );

  mw_data_shifter #(.DATA_W(DATA_W)) u_dat (
    .clk    (clk),
    .rst    (rst),
    .clear  (accept),
    .sample (dat_sample),
    .din    (do_i),
    .word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= MW_IDLE;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      word_o   <= '0;
      cs_o     <= 1'b0;
      sk_o     <= 1'b0;
      dcnt     <= '0;
      gap_half <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        MW_IDLE: begin
          if (start_i) begin
            phase    <= MW_LEAD;
            busy_o   <= 1'b1;
            cs_o     <= 1'b1;
            sk_o     <= 1'b0;
            dcnt     <= '0;
            gap_half <= 1'b0;
          end
        end
        MW_LEAD: begin
          if (tick) phase <= MW_CMD_LO;
        end
        MW_CMD_LO: begin
          if (tick) begin
            phase <= MW_CMD_HI;
            sk_o  <= 1'b1;
          end
        end
        MW_CMD_HI: begin
          if (tick) begin
            sk_o  <= 1'b0;
            phase <= cmd_last ? MW_DAT_LO : MW_CMD_LO;
          end
        end
        MW_DAT_LO: begin
          if (tick) begin
            phase <= MW_DAT_HI;
            sk_o  <= 1'b1;
          end
        end
        MW_DAT_HI: begin
          if (tick) begin
            sk_o <= 1'b0;
            dcnt <= dcnt + 1'b1;
            if (dcnt == DLAST) begin
              phase <= MW_GAP;
              cs_o  <= 1'b0;
            end else begin
              phase <= MW_DAT_LO;
            end
          end
        end
        MW_GAP: begin
          if (tick) begin
            if (gap_half) begin
              phase  <= MW_IDLE;
              busy_o <= 1'b0;
              done_o <= 1'b1;
              word_o <= rx_word;
            end else begin
              gap_half <= 1'b1;
            end
          end
        end
        default: phase <= MW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk #(
  parameter int HALF_DIV = 1250
) (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_o,
  input logic sk_o,
  input logic di_o
);
  logic        sk_q;
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      sk_q    <= 1'b0;
      run_len <= 32'd0;
    end else begin
      sk_q <= sk_o;
      if (sk_o != sk_q)            run_len <= 32'd1;
      else if (run_len != '1)      run_len <= run_len + 32'd1;
    end
  end

  AST_DI_HELD_WHILE_SK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sk_o && $past(sk_o)) |-> $stable(di_o)); // R5
  AST_HIGH_HALF_WIDTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(sk_o) && $past(cs_o)) |-> (run_len == 32'(HALF_DIV))); // R5
  AST_SK_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    !cs_o |-> !sk_o); // R6
  AST_SELECT_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    cs_o |-> busy_o); // R6
  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R7
  AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R8
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i)); // R8
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .cs_o    (cs_o),
  .sk_o    (sk_o),
  .di_o    (di_o)
);

// File: tb/test_mw_eeprom_reader.sv
`timescale 1ns/1ps
module test_mw_eeprom_reader;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wide_i = 1'b0;
  logic        busy_o, done_o, cs_o, sk_o, di_o;
  logic [15:0] word_o;
  logic        do_i = 1'b0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mw_eeprom_reader #(.HALF_DIV(H)) i_mw_eeprom_reader (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .wide_i(wide_i),
    .busy_o(busy_o), .done_o(done_o), .word_o(word_o),
    .cs_o(cs_o), .sk_o(sk_o), .di_o(di_o), .do_i(do_i)
  );

  function automatic logic [15:0] pattern(input int a);
    return 16'((a * 1103) ^ 16'hC3A5 ^ (a << 9));
  endfunction

  // EEPROM model
  logic        m_wide = 1'b0;
  int          rises = 0;
  int          win_rises = 0;
  logic [10:0] cap = '0;
  logic [2:0]  seen_op = '0;
  int          seen_addr = 0;
  logic [15:0] m_word = '0;

  always @(posedge cs_o) begin
    rises = 0;
    cap   = '0;
  end

  always @(negedge cs_o) win_rises = rises;

  always @(posedge sk_o) begin
    if (cs_o) begin
      int n;
      n = m_wide ? 11 : 9;
      rises = rises + 1;
      if (rises <= n) begin
        cap = {cap[9:0], di_o};
        if (rises == n) begin
          seen_op   = m_wide ? cap[10:8] : cap[8:6];
          seen_addr = m_wide ? int'(cap[7:0]) : int'(cap[5:0]);
          m_word    = pattern(seen_addr);
        end
      end else if (rises <= n + 16) begin
        do_i <= m_word[15 - (rises - n - 1)];
      end
    end
  end

  // line monitors
  int  low_run = 0;
  int  min_gap = 1000000;
  bit  had_sel = 0;
  bit  prev_cs = 0;
  bit  pend = 0;
  int  lead = 0;
  int  lead_last = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (!cs_o) begin
        low_run++;
      end else begin
        if (had_sel && low_run > 0 && low_run < min_gap) min_gap = low_run;
        low_run = 0;
        had_sel = 1;
      end
      if (cs_o && !prev_cs) begin
        pend = 1;
        lead = 0;
      end
      if (pend) begin
        if (sk_o) begin
          lead_last = lead;
          pend = 0;
        end else begin
          lead++;
        end
      end
      prev_cs = cs_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] a, input logic w);
    m_wide  = w;
    addr_i  = a;
    wide_i  = w;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int expa, input logic w, input int lat0, input string atag);
    int lat;
    int n;
    int early;
    n = w ? 11 : 9;
    lat = lat0;
    early = 0;
    while (!done_o && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (!done_o && !busy_o) early++;
    end
    check(done_o == 1'b1, "R7 done seen", int'(done_o), 1);
    check(lat == H * (35 + 2 * n), "R7 latency", lat, H * (35 + 2 * n));
    check(word_o == pattern(expa), "R4 word", int'(word_o), int'(pattern(expa)));
    check(seen_op == 3'b110, "R2 opcode", int'(seen_op), 6);
    check(seen_addr == expa, atag, seen_addr, expa);
    check(win_rises == n + 16, "R6 clock count", win_rises, n + 16);
    check(lead_last == 2 * H, "R6 lead time", lead_last, 2 * H);
    check(busy_o == 1'b0, "R8 busy low at done", int'(busy_o), 0);
    check(early == 0, "R8 busy held", early, 0);
  endtask

  task automatic post_check(input int expa);
    @(negedge clk);
    check(done_o == 1'b0, "R7 pulse width", int'(done_o), 0);
    check(word_o == pattern(expa), "R7 word held", int'(word_o), int'(pattern(expa)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cs_o == 0 && sk_o == 0 && di_o == 0, "R1 lines idle", int'({cs_o, sk_o, di_o}), 0);
    check(busy_o == 0 && done_o == 0, "R1 flags idle", int'({busy_o, done_o}), 0);
    check(word_o == 16'h0, "R1 word zero", int'(word_o), 0);
    repeat (2) @(negedge clk);

    // R2 long addresses, full sweep
    for (int a = 0; a < 256; a++) begin
      issue(8'(a), 1'b1);
      wait_done(a, 1'b1, 0, "R2 long address");
      post_check(a);
    end

    // R2 short addresses, full sweep
    for (int a = 0; a < 64; a++) begin
      issue(8'(a), 1'b0);
      wait_done(a, 1'b0, 0, "R2 short address");
      post_check(a);
    end

    // R3 upper bits ignored in short mode
    for (int a = 0; a < 64; a++) begin
      issue(8'(a) | 8'hC0, 1'b0);
      wait_done(a, 1'b0, 0, "R3 upper bits ignored");
      post_check(a);
    end

    // R8 start while busy is ignored
    issue(8'h5A, 1'b1);
    repeat (40) @(negedge clk);
    addr_i  = 8'hA7;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R8 still busy", int'(busy_o), 1);
    wait_done(8'h5A, 1'b1, 41, "R8 address kept");
    post_check(8'h5A);
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R8 no second read", int'(busy_o), 0);

    // R9 start in the done cycle, chained reads
    issue(8'h11, 1'b1);
    wait_done(8'h11, 1'b1, 0, "R9 first chained");
    for (int k = 0; k < 4; k++) begin
      issue(8'(8'h20 + k * 37), 1'b1);
      wait_done(8'h20 + k * 37, 1'b1, 0, "R9 chained address");
    end
    post_check(8'h20 + 3 * 37);
    issue(8'h2B, 1'b0);
    wait_done(8'h2B, 1'b0, 0, "R9 chained short");
    post_check(8'h2B);
    check(min_gap >= 2 * H, "R9 deselect gap", min_gap, 2 * H);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule